// File: doc/BRIEF.md
# Context-Tagged Translation Buffer with Level-Aware Flush

This block is a small, fully associative cache of final page table entries. Each slot holds a 32-bit entry, the 20-bit virtual page number it was filled with, an address-space context number, and the size of the mapping: a 16 MB region, a 256 KB segment or a 4 KB page. A translate port returns hit and entry combinationally for any virtual address and context. An external table walker supplies new entries through a fill port. Each fill is placed in the next slot in round-robin order.

A register-mapped maintenance port does two jobs. A write there is a flush. Address bits 10:8 select its reach:

| Code | Reach of the flush |
|------|--------------------|
| 0 | page |
| 1 | segment |
| 2 | region |
| 3 | current context |
| 4 | everything |

A read with code 4 is a probe. It returns the cached entry covering the page in the current context. A flush removes an entry whenever the flushed range and the entry's own mapping overlap. The comparison therefore runs at whichever of the two sizes is coarser.

The fill port uses valid/ready. A fill transfers on a clock edge where `fill_valid` and `fill_ready` are both high. `fill_ready` drops for any cycle in which a flush write is present. The walker must then hold its request until ready returns. The maintenance and translate ports are plain, with no handshake.

Top module: `ctx_tlb`

## Requirements
- R1: After reset every slot is empty. Every translation misses with `lu_pte` = 0, every probe returns 0, and `fill_ready` is high.
- R2: A translation hits when a valid slot's context equals `lu_ctx` and the virtual address matches the slot on bits 31:24 (level code 1), bits 31:18 (level code 2) or bits 31:12 (level code 3). The result is combinational: `lu_hit` is 1 and `lu_pte` carries the stored entry. On a miss `lu_pte` is 0.
- R3: `fill_ready` is low in any cycle with `fp_wr` high, and a fill offered then is not taken. An accepted fill becomes visible to translations in the cycle after its clock edge. A fill with level code 0 is accepted but discarded, and the victim pointer does not move.
- R4: Accepted fills with a nonzero level go to slots 0,1,…,N_ENT-1 in turn and then wrap. When all slots are full, the oldest fill is the one replaced, whether or not other slots are empty.
- R5: A write with `fp_addr[10:8]` = 4 empties every slot, whatever its context, from the next cycle on.
- R6: A write with `fp_addr[10:8]` = 3 empties every slot whose context equals `cur_ctx`.
- R7: A write with `fp_addr[10:8]` = 2 empties every slot of context `cur_ctx` whose mapping overlaps the 16 MB region given by `fp_addr[31:24]`.
- R8: A write with `fp_addr[10:8]` = 1 empties every slot of context `cur_ctx` whose mapping overlaps the 256 KB segment given by `fp_addr[31:18]`. This includes a region slot that contains the segment.
- R9: A write with `fp_addr[10:8]` = 0 empties every slot of context `cur_ctx` whose mapping contains the page `fp_addr[31:12]`. This includes larger slots that contain the page.
- R10: A write with `fp_addr[10:8]` of 5, 6 or 7 changes nothing.
- R11: While `fp_rd` is high with `fp_addr[10:8]` = 4, `fp_rdata` is the entry that a translation of `fp_addr[31:12]` in context `cur_ctx` would return, or 0 on a miss. A read with any other code returns 0.
- R12: When several slots match one translation or probe, the lowest-numbered slot supplies the entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lu_va | input | 32 | Virtual address to translate |
| lu_ctx | input | CTX_W | Context of the translation |
| lu_hit | output | 1 | Translation found |
| lu_pte | output | 32 | Matching entry, 0 on miss |
| fill_valid | input | 1 | Walker offers an entry |
| fill_ready | output | 1 | Fill can be taken this cycle |
| fill_va | input | 32 | Virtual address of the offered entry |
| fill_ctx | input | CTX_W | Context of the offered entry |
| fill_lvl | input | 2 | Mapping size: 1 = 16 MB, 2 = 256 KB, 3 = 4 KB, 0 = discard |
| fill_pte | input | 32 | Entry value |
| cur_ctx | input | CTX_W | Context used by flushes and probes |
| fp_addr | input | 32 | Maintenance address, bits 10:8 select the operation |
| fp_wr | input | 1 | Flush strobe |
| fp_rd | input | 1 | Probe strobe |
| fp_rdata | output | 32 | Probe result |

## Verification
The bench builds the block with four slots and a 3-bit context. With only four slots, the wrap of the victim pointer and the eviction of live entries by later fills occur after a handful of fills. This means overlap between slots of different sizes, and the lowest-index rule, arise on purpose within short scenarios. After every operation the bench sweeps translations and probes over each slot's page with single bits flipped at positions 12, 18, 24 and 31, in both the matching and a neighbouring context. It compares every result with an arithmetic model of slot contents, mapping sizes and flush reach.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;
  localparam int VPN_W = 20;
  localparam int PTE_W = 32;

  typedef enum logic [1:0] {
    LVL_NONE   = 2'd0,
    LVL_REGION = 2'd1,
    LVL_SEG    = 2'd2,
    LVL_PAGE   = 2'd3
  } lvl_e;

  localparam logic [2:0] OP_PAGE   = 3'd0;
  localparam logic [2:0] OP_SEG    = 3'd1;
  localparam logic [2:0] OP_REGION = 3'd2;
  localparam logic [2:0] OP_CTX    = 3'd3;
  localparam logic [2:0] OP_ALL    = 3'd4;

  // Page-number bits that an entry of the given size compares.
  function automatic logic [VPN_W-1:0] size_mask(lvl_e l);
    case (l)
      LVL_REGION: size_mask = 20'hFF000;
      LVL_SEG:    size_mask = 20'hFFFC0;
      default:    size_mask = 20'hFFFFF;
    endcase
  endfunction

  // Page-number bits that a flush operation compares.
  function automatic logic [VPN_W-1:0] op_mask(logic [2:0] op);
    case (op)
      OP_PAGE:   op_mask = 20'hFFFFF;
      OP_SEG:    op_mask = 20'hFFFC0;
      OP_REGION: op_mask = 20'hFF000;
      default:   op_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/ctx_tlb_rr.sv
module ctx_tlb_rr #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [IW-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= (ptr == IW'(N - 1)) ? '0 : ptr + 1'b1;
  end

  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr));
  assert_ptr_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> ptr != $past(ptr));
endmodule

// File: rtl/ctx_tlb_entry.sv
module ctx_tlb_entry
  import ctx_tlb_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [CTX_W-1:0] wr_ctx,
  input  lvl_e             wr_lvl,
  input  logic [PTE_W-1:0] wr_pte,
  input  logic [VPN_W-1:0] lu_vpn,
  input  logic [CTX_W-1:0] lu_ctx,
  output logic             lu_match,
  input  logic [VPN_W-1:0] pr_vpn,
  input  logic [CTX_W-1:0] pr_ctx,
  output logic             pr_match,
  input  logic             fl_en,
  input  logic             fl_all,
  input  logic [VPN_W-1:0] fl_vpn,
  input  logic [VPN_W-1:0] fl_mask,
  input  logic [CTX_W-1:0] fl_ctx,
  output logic             valid_o,
  output logic [PTE_W-1:0] pte_o
);
  logic             valid_q;
  logic [VPN_W-1:0] vpn_q;
  logic [CTX_W-1:0] ctx_q;
  lvl_e             lvl_q;
  logic [PTE_W-1:0] pte_q;
  logic [VPN_W-1:0] smask;
  logic             kill;

  assign smask    = size_mask(lvl_q);
  assign lu_match = valid_q && (ctx_q == lu_ctx) && (((vpn_q ^ lu_vpn) & smask) == '0);
  assign pr_match = valid_q && (ctx_q == pr_ctx) && (((vpn_q ^ pr_vpn) & smask) == '0);
  // Overlap test at the coarser of entry size and flush reach.
  assign kill = fl_en && (fl_all ||
                ((ctx_q == fl_ctx) && (((vpn_q ^ fl_vpn) & smask & fl_mask) == '0)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vpn_q   <= '0;
      ctx_q   <= '0;
      lvl_q   <= LVL_NONE;
      pte_q   <= '0;
    end else if (kill) begin
      valid_q <= 1'b0;
    end else if (wr_en) begin
      valid_q <= 1'b1;
      vpn_q   <= wr_vpn;
      ctx_q   <= wr_ctx;
      lvl_q   <= wr_lvl;
      pte_q   <= wr_pte;
    end
  end

  assign valid_o = valid_q;
  assign pte_o   = pte_q;

  assert_flush_all_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fl_en && fl_all |=> !valid_q);
  assert_ctx_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fl_en && !fl_all && (fl_mask == '0) && (ctx_q == fl_ctx) |=> !valid_q);
  assert_other_ctx_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fl_en && !fl_all && (ctx_q != fl_ctx) && !wr_en |=> valid_q == $past(valid_q));
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import ctx_tlb_pkg::*;
#(
  parameter int N_ENT = 8,
  parameter int CTX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      lu_va,
  input  logic [CTX_W-1:0] lu_ctx,
  output logic             lu_hit,
  output logic [31:0]      lu_pte,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [31:0]      fill_va,
  input  logic [CTX_W-1:0] fill_ctx,
  input  logic [1:0]       fill_lvl,
  input  logic [31:0]      fill_pte,
  input  logic [CTX_W-1:0] cur_ctx,
  input  logic [31:0]      fp_addr,
  input  logic             fp_wr,
  input  logic             fp_rd,
  output logic [31:0]      fp_rdata
);
  localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic [2:0]       op;
  logic             fill_fire;
  logic [IW-1:0]    vic_ptr;
  logic [N_ENT-1:0] lu_m, pr_m, ent_valid, wr_en;
  logic [PTE_W-1:0] ent_pte [N_ENT];
  logic             pr_hit;
  logic [PTE_W-1:0] pr_pte;
  logic             unused_bits;

  assign op          = fp_addr[10:8];
  assign fill_ready  = !fp_wr;
  assign fill_fire   = fill_valid && fill_ready && (fill_lvl != 2'd0);
  assign unused_bits = ^{lu_va[11:0], fill_va[11:0], fp_addr[11], fp_addr[7:0]};

  ctx_tlb_rr #(.N(N_ENT)) rr_i (
    .clk(clk), .rst_n(rst_n), .adv(fill_fire), .ptr(vic_ptr)
  );

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    assign wr_en[i] = fill_fire && (vic_ptr == IW'(i));
    ctx_tlb_entry #(.CTX_W(CTX_W)) ent_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en[i]), .wr_vpn(fill_va[31:12]), .wr_ctx(fill_ctx),
      .wr_lvl(lvl_e'(fill_lvl)), .wr_pte(fill_pte),
      .lu_vpn(lu_va[31:12]), .lu_ctx(lu_ctx), .lu_match(lu_m[i]),
      .pr_vpn(fp_addr[31:12]), .pr_ctx(cur_ctx), .pr_match(pr_m[i]),
      .fl_en(fp_wr && (op <= OP_ALL)), .fl_all(op == OP_ALL),
      .fl_vpn(fp_addr[31:12]), .fl_mask(op_mask(op)), .fl_ctx(cur_ctx),
      .valid_o(ent_valid[i]), .pte_o(ent_pte[i])
    );
  end

  // Lowest index wins: scan downward so the last assignment is the lowest.
  always_comb begin
    lu_hit = 1'b0;
    lu_pte = '0;
    pr_hit = 1'b0;
    pr_pte = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (lu_m[i]) begin
        lu_hit = 1'b1;
        lu_pte = ent_pte[i];
      end
      if (pr_m[i]) begin
        pr_hit = 1'b1;
        pr_pte = ent_pte[i];
      end
    end
  end

  assign fp_rdata = (fp_rd && (op == OP_ALL) && pr_hit) ? pr_pte : '0;

  assert_fill_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> ent_valid[$past(vic_ptr)]);
  assert_fill_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && fp_wr |=> $stable(vic_ptr));
  assert_probe_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fp_rd && (fp_addr[10:8] != 3'd4) |-> fp_rdata == '0);
  assert_miss_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lu_hit |-> lu_pte == '0);
  assert_reset_empty_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> ent_valid == '0);
endmodule

// File: tb/ctx_tlb_tb.sv
module ctx_tlb_tb_top;
  localparam int NE = 4;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   lu_va = '0;
  logic [CW-1:0] lu_ctx = '0;
  logic          lu_hit;
  logic [31:0]   lu_pte;
  logic          fill_valid = 1'b0;
  logic          fill_ready;
  logic [31:0]   fill_va = '0;
  logic [CW-1:0] fill_ctx = '0;
  logic [1:0]    fill_lvl = '0;
  logic [31:0]   fill_pte = '0;
  logic [CW-1:0] cur_ctx = '0;
  logic [31:0]   fp_addr = '0;
  logic          fp_wr = 1'b0;
  logic          fp_rd = 1'b0;
  logic [31:0]   fp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit            m_v   [NE];
  logic [19:0]   m_vpn [NE];
  logic [CW-1:0] m_ctx [NE];
  logic [1:0]    m_lvl [NE];
  logic [31:0]   m_pte [NE];
  int            m_ptr = 0;

  ctx_tlb #(.N_ENT(NE), .CTX_W(CW)) dut_i (.*);

  always #5 clk = ~clk;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] lm(logic [1:0] l);
    return (l == 2'd1) ? 20'hFF000 : (l == 2'd2) ? 20'hFFFC0 : 20'hFFFFF;
  endfunction

  function automatic logic [19:0] fm(logic [2:0] k);
    return (k == 3'd0) ? 20'hFFFFF : (k == 3'd1) ? 20'hFFFC0 : 20'hFF000;
  endfunction

  function automatic logic [32:0] m_look(logic [31:0] va, logic [CW-1:0] c);
    for (int i = 0; i < NE; i++)
      if (m_v[i] && m_ctx[i] == c && ((m_vpn[i] ^ va[31:12]) & lm(m_lvl[i])) == '0)
        return {1'b1, m_pte[i]};
    return '0;
  endfunction

  task automatic look(logic [31:0] va, logic [CW-1:0] c, bit eh, logic [31:0] ep, string req);
    lu_va = va; lu_ctx = c; #1;
    chk(lu_hit == eh, req, "lu_hit", {31'd0, lu_hit}, {31'd0, eh});
    chk(lu_pte == ep, req, "lu_pte", lu_pte, ep);
  endtask

  task automatic probe(logic [31:0] addr, logic [CW-1:0] c, logic [31:0] ep, string req);
    cur_ctx = c; fp_addr = addr; fp_rd = 1'b1; #1;
    chk(fp_rdata == ep, req, "fp_rdata", fp_rdata, ep);
    fp_rd = 1'b0;
  endtask

  task automatic do_fill(logic [31:0] va, logic [CW-1:0] c, logic [1:0] l, logic [31:0] p);
    fill_va = va; fill_ctx = c; fill_lvl = l; fill_pte = p; fill_valid = 1'b1; #1;
    chk(fill_ready, "R3", "fill_ready idle", {31'd0, fill_ready}, 32'd1);
    @(posedge clk);
    if (l != 2'd0) begin
      m_v[m_ptr] = 1; m_vpn[m_ptr] = va[31:12]; m_ctx[m_ptr] = c;
      m_lvl[m_ptr] = l; m_pte[m_ptr] = p;
      m_ptr = (m_ptr + 1) % NE;
    end
    #1 fill_valid = 1'b0;
  endtask

  task automatic do_flush(logic [31:0] addr, logic [CW-1:0] c, bit with_fill);
    logic [2:0] k;
    k = addr[10:8];
    cur_ctx = c; fp_addr = addr; fp_wr = 1'b1;
    if (with_fill) begin
      fill_va = 32'h7777_7000; fill_ctx = c; fill_lvl = 2'd3;
      fill_pte = 32'h7777_708E; fill_valid = 1'b1;
    end
    #1;
    if (with_fill) chk(!fill_ready, "R3", "fill_ready during flush", {31'd0, fill_ready}, 32'd0);
    @(posedge clk);
    for (int i = 0; i < NE; i++) begin
      if (m_v[i]) begin
        if (k == 3'd4) m_v[i] = 0;
        else if (k == 3'd3 && m_ctx[i] == c) m_v[i] = 0;
        else if (k <= 3'd2 && m_ctx[i] == c &&
                 ((m_vpn[i] ^ addr[31:12]) & lm(m_lvl[i]) & fm(k)) == '0) m_v[i] = 0;
      end
    end
    #1 fp_wr = 1'b0; fill_valid = 1'b0;
  endtask

  task automatic sweep(string req);
    logic [31:0] va;
    logic [CW-1:0] c;
    logic [32:0] e;
    for (int i = 0; i < NE; i++)
      for (int d = 0; d < 5; d++)
        for (int x = 0; x < 2; x++) begin
          va = {m_vpn[i], 12'h5A4};
          if (d == 1) va ^= 32'h0000_1000;
          if (d == 2) va ^= 32'h0004_0000;
          if (d == 3) va ^= 32'h0100_0000;
          if (d == 4) va ^= 32'h8000_0000;
          c = m_ctx[i] ^ CW'(x);
          e = m_look(va, c);
          look(va, c, e[32], e[31:0], req);
          probe({va[31:12], 12'h400}, c, e[31:0], "R11");
        end
  endtask

  initial begin
    for (int i = 0; i < NE; i++) begin
      m_v[i] = 0; m_vpn[i] = '0; m_ctx[i] = '0; m_lvl[i] = '0; m_pte[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    look(32'h1234_5000, 3'd1, 0, 32'h0, "R1");
    probe(32'h1234_5400, 3'd1, 32'h0, "R1");
    chk(fill_ready, "R1", "fill_ready", {31'd0, fill_ready}, 32'd1);
    sweep("R1");

    do_fill(32'h1234_5678, 3'd1, 2'd3, 32'hA000_001E); // slot0
    do_fill(32'h1234_5678, 3'd2, 2'd2, 32'hB000_002E); // slot1
    do_fill(32'h9A00_0000, 3'd1, 2'd1, 32'hC000_003E); // slot2
    do_fill(32'h5555_5000, 3'd1, 2'd0, 32'hEEEE_EEEE); // R3 discarded
    look(32'h5555_5000, 3'd1, 0, 32'h0, "R3");
    do_fill(32'h1238_0000, 3'd1, 2'd3, 32'hD000_004E); // slot3
    // R2 level granularity and context
    look(32'h1234_5FFF, 3'd1, 1, 32'hA000_001E, "R2");
    look(32'h1234_6000, 3'd1, 0, 32'h0, "R2");
    look(32'h1237_F000, 3'd2, 1, 32'hB000_002E, "R2");
    look(32'h1234_5000, 3'd3, 0, 32'h0, "R2");
    look(32'h9AFF_F000, 3'd1, 1, 32'hC000_003E, "R2");
    look(32'h9B00_0000, 3'd1, 0, 32'h0, "R2");
    sweep("R2");

    // R4 wrap replaces oldest; R12 lowest slot wins over region slot2
    do_fill(32'h9A12_3000, 3'd1, 2'd3, 32'h6000_005E); // slot0
    look(32'h1234_5000, 3'd1, 0, 32'h0, "R4");
    look(32'h9A12_3000, 3'd1, 1, 32'h6000_005E, "R12");
    probe(32'h9A12_3400, 3'd1, 32'h6000_005E, "R12");
    look(32'h9A12_4000, 3'd1, 1, 32'hC000_003E, "R12");

    // R3 fill offered with a flush write; R10 reserved codes
    do_flush(32'h9A12_3500, 3'd1, 1);
    look(32'h7777_7000, 3'd1, 0, 32'h0, "R3");
    do_flush(32'h9A12_3600, 3'd1, 0);
    do_flush(32'h9A12_3700, 3'd1, 0);
    look(32'h9A12_3000, 3'd1, 1, 32'h6000_005E, "R10");
    sweep("R10");

    // R9 page flush also removes the enclosing region slot
    do_flush(32'h9A12_30BC, 3'd1, 0);
    look(32'h9A12_3000, 3'd1, 0, 32'h0, "R9");
    look(32'h9A45_6000, 3'd1, 0, 32'h0, "R9");
    look(32'h1238_0000, 3'd1, 1, 32'hD000_004E, "R9");
    sweep("R9");

    // R8 segment flush
    do_fill(32'h1234_5000, 3'd1, 2'd3, 32'h1100_001E); // slot1
    do_fill(32'h9A00_0000, 3'd1, 2'd1, 32'h2200_002E); // slot2
    do_fill(32'h1234_5678, 3'd2, 2'd2, 32'h3300_003E); // slot3
    do_fill(32'h1238_0000, 3'd1, 2'd3, 32'h4400_004E); // slot0
    do_flush(32'h1234_0100, 3'd1, 0);
    look(32'h1234_5000, 3'd1, 0, 32'h0, "R8");
    look(32'h1238_0000, 3'd1, 1, 32'h4400_004E, "R8");
    look(32'h1234_5000, 3'd2, 1, 32'h3300_003E, "R8");
    do_flush(32'h9A04_0100, 3'd1, 0);
    look(32'h9A00_0000, 3'd1, 0, 32'h0, "R8");
    sweep("R8");

    // R7 region flush only in current context
    do_flush(32'h1200_0200, 3'd2, 0);
    look(32'h1234_5000, 3'd2, 0, 32'h0, "R7");
    look(32'h1238_0000, 3'd1, 1, 32'h4400_004E, "R7");
    sweep("R7");

    // R6 context flush
    do_fill(32'h4000_0000, 3'd2, 2'd1, 32'h5500_005E); // slot1
    do_flush(32'h0000_0300, 3'd1, 0);
    look(32'h1238_0000, 3'd1, 0, 32'h0, "R6");
    look(32'h40AB_C000, 3'd2, 1, 32'h5500_005E, "R6");
    sweep("R6");

    // R11 probe codes
    probe(32'h4000_0300, 3'd2, 32'h0, "R11");
    probe(32'h4000_0400, 3'd2, 32'h5500_005E, "R11");
    probe(32'h4000_0400, 3'd1, 32'h0, "R11");

    // R4 five fills into four slots: first of them evicted
    for (int p = 1; p <= 5; p++)
      do_fill({20'(p), 12'h0}, 3'd5, 2'd3, 32'h0900_000E + 32'(p << 8));
    look(32'h0000_1000, 3'd5, 0, 32'h0, "R4");
    for (int p = 2; p <= 5; p++)
      look({20'(p), 12'h0}, 3'd5, 1, 32'h0900_000E + 32'(p << 8), "R4");
    sweep("R4");

    // R5 flush everything regardless of context
    do_flush(32'h0000_0400, 3'd7, 0);
    look(32'h0000_3000, 3'd5, 0, 32'h0, "R5");
    sweep("R5");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule